// File: doc/BRIEF.md
# Parallel Flash Command Interface

This block presents a small NOR-style flash to a host over an asynchronous-style parallel bus: chip enable, output enable, write enable, an active-low reset, an address and a byte-wide data path split into input, output and output-enable. The storage is an on-chip register array that is split into equal sectors, and each sector has a lock bit. All bus inputs are sampled by a system clock. Program, erase and abort times are parameterised counts of that clock.

A read with both enables low and write enable high returns the stored byte. No write changes storage directly. Writes feed a decoder that only accepts fixed unlock sequences. Each sequence then starts one of the following: a byte program, a sector erase or a chip erase, which run timed in the background, or a sector lockdown, which takes effect at once. During a timed operation, reads return a polling status word in place of array data. When the operation ends, the block goes back to plain reads without any outside action.

Top module: `flash_cmd_top`

## Requirements
- R1: With ce_n and oe_n low, we_n high and rst_n high, dout_oe is high and dout shows the byte stored at addr[MEM_AW-1:0] when no operation is running.
- R2: dout_oe is low whenever ce_n or oe_n is high.
- R3: A write strobe is the interval in which ce_n and we_n are low and oe_n is high. The address is captured when the strobe opens and the data when it closes, so an address change inside the strobe has no effect and a data change inside it does.
- R4: While rst_n is low, dout_oe is low and any running operation is abandoned. After rst_n returns high, reads return array data, not status, and the lock bits reload from LOCK_INIT.
- R5: Every byte powers up as FFh. A program stores the old byte AND the written byte, so no bit can go from 0 to 1 through a program.
- R6: Byte program is the writes AAh@555h, 55h@2AAh, A0h@555h, then data@target. The byte is updated PROG_CYCLES clocks after the last strobe closes.
- R7: Erase is AAh@555h, 55h@2AAh, 80h@555h, AAh@555h, 55h@2AAh followed by either 10h@555h, which erases the whole array, or 30h at any address in the sector, which erases that sector. The erased bytes read FFh after ERASE_CYCLES clocks and every other sector keeps its contents.
- R8: Every write strobe that closes during a running operation is ignored, including a complete command sequence.
- R9: Chip erase leaves locked sectors untouched. A program or sector erase aimed at a locked sector changes nothing and ends after ABORT_CYCLES clocks.
- R10: Once the operation's time has elapsed, the block returns to reads of array data on its own.
- R11: During an operation, a read returns a status byte. Bit 7 is the complement of bit 7 of the programmed byte (0 for an erase). Bit 6 is 0 on the first read after the operation starts and inverts after each completed read. Bits 5..0 are 0.
- R12: A write whose address or data does not match the expected step of a sequence returns the decoder to idle, so later steps of that sequence have no effect.
- R13: The writes AAh@555h, 55h@2AAh, 60h@555h, 40h@sector-address set the lock bit of that sector. Lock bit s guards addresses whose bits [MEM_AW-1:SEC_AW] equal s.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the bus and times operations |
| rst_n | input | 1 | Active-low reset; aborts operations, tri-states data |
| ce_n | input | 1 | Active-low chip enable |
| oe_n | input | 1 | Active-low output enable |
| we_n | input | 1 | Active-low write enable |
| addr | input | ADDR_W | Bus address |
| din | input | DATA_W | Write data from the host |
| dout | output | DATA_W | Read data or status byte |
| dout_oe | output | 1 | High when the block drives the data bus |

## Verification
The properties assume that the host bus is synchronous to clk. Each strobe must be at least one clock wide, and a read must never overlap a write strobe. The bench drives every control change on the falling clock edge and holds each level for whole cycles. Read and write accesses always have idle cycles between them, so each strobe edge is seen exactly once. The properties also assume that no new command can complete before the decoder sees the busy flag. The bench keeps the host from issuing anything that depends on that, because it only issues commands after waits longer than the operation times it sets.

// File: rtl/flash_pkg.sv
`timescale 1ns/1ps
package flash_pkg;
   typedef enum logic [1:0] {OP_PROG = 2'd0, OP_SECT = 2'd1, OP_CHIP = 2'd2} op_e;
   typedef enum logic [2:0] {
      SQ_IDLE, SQ_KEY1, SQ_KEY2, SQ_PROG, SQ_ERA1, SQ_ERA2, SQ_ERA3, SQ_LOCK
   } seq_e;
   localparam logic [7:0] C_KEY_A    = 8'hAA;
   localparam logic [7:0] C_KEY_B    = 8'h55;
   localparam logic [7:0] C_PROGRAM  = 8'hA0;
   localparam logic [7:0] C_ERASE    = 8'h80;
   localparam logic [7:0] C_WHOLE    = 8'h10;
   localparam logic [7:0] C_SECTOR   = 8'h30;
   localparam logic [7:0] C_LOCK_ARM = 8'h60;
   localparam logic [7:0] C_LOCK_GO  = 8'h40;
   localparam int unsigned KEY_ADDR_A = 32'h555;
   localparam int unsigned KEY_ADDR_B = 32'h2AA;
endpackage

// File: rtl/flash_bus_strobe.sv
`timescale 1ns/1ps
module flash_bus_strobe #(
   parameter int unsigned ADDR_W = 12,
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ce_n,
   input  logic              oe_n,
   input  logic              we_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] din,
   output logic              commit,
   output logic [ADDR_W-1:0] addr_lat,
   output logic [DATA_W-1:0] data_lat,
   output logic              rd_end
);
   logic wr_now, wr_q, rd_now, rd_q;

   assign wr_now = ~ce_n & ~we_n & oe_n;
   assign rd_now = ~ce_n & ~oe_n & we_n;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_q     <= 1'b0;
         rd_q     <= 1'b0;
         addr_lat <= '0;
         data_lat <= '0;
      end else begin
         wr_q <= wr_now;
         rd_q <= rd_now;
         if (wr_now && !wr_q) addr_lat <= addr;
         if (wr_now)          data_lat <= din;
      end
   end

   assign commit = wr_q & ~wr_now;
   assign rd_end = rd_q & ~rd_now;
endmodule

// File: rtl/flash_seq_decoder.sv
`timescale 1ns/1ps
module flash_seq_decoder
   import flash_pkg::*;
#(
   parameter int unsigned ADDR_W = 12,
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              commit,
   input  logic              busy,
   input  logic [ADDR_W-1:0] addr_lat,
   input  logic [DATA_W-1:0] data_lat,
   output logic              start,
   output op_e               op,
   output logic              lock_set
);
   seq_e state, nxt;
   logic at_a, at_b;

   assign at_a = (addr_lat == ADDR_W'(KEY_ADDR_A));
   assign at_b = (addr_lat == ADDR_W'(KEY_ADDR_B));

   always_comb begin
      nxt      = state;
      start    = 1'b0;
      op       = OP_PROG;
      lock_set = 1'b0;
      if (busy) begin
         nxt = SQ_IDLE;
      end else if (commit) begin
         nxt = SQ_IDLE;
         case (state)
            SQ_IDLE: if (at_a && data_lat == C_KEY_A) nxt = SQ_KEY1;
            SQ_KEY1: if (at_b && data_lat == C_KEY_B) nxt = SQ_KEY2;
            SQ_KEY2: begin
               if (at_a && data_lat == C_PROGRAM)       nxt = SQ_PROG;
               else if (at_a && data_lat == C_ERASE)    nxt = SQ_ERA1;
               else if (at_a && data_lat == C_LOCK_ARM) nxt = SQ_LOCK;
            end
            SQ_PROG: begin
               start = 1'b1;
               op    = OP_PROG;
            end
            SQ_ERA1: if (at_a && data_lat == C_KEY_A) nxt = SQ_ERA2;
            SQ_ERA2: if (at_b && data_lat == C_KEY_B) nxt = SQ_ERA3;
            SQ_ERA3: begin
               if (at_a && data_lat == C_WHOLE) begin
                  start = 1'b1;
                  op    = OP_CHIP;
               end else if (data_lat == C_SECTOR) begin
                  start = 1'b1;
                  op    = OP_SECT;
               end
            end
            SQ_LOCK: lock_set = (data_lat == C_LOCK_GO);
            default: nxt = SQ_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state <= SQ_IDLE;
      else        state <= nxt;
   end
endmodule

// File: rtl/flash_op_engine.sv
`timescale 1ns/1ps
module flash_op_engine
   import flash_pkg::*;
#(
   parameter int unsigned DATA_W       = 8,
   parameter int unsigned MEM_AW       = 8,
   parameter int unsigned SEC_AW       = 5,
   parameter int unsigned NUM_SEC      = 8,
   parameter int unsigned PROG_CYCLES  = 16,
   parameter int unsigned ERASE_CYCLES = 64,
   parameter int unsigned ABORT_CYCLES = 400,
   parameter logic [NUM_SEC-1:0] LOCK_INIT = '0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  op_e                op,
   input  logic [MEM_AW-1:0]  tgt_addr,
   input  logic [DATA_W-1:0]  tgt_data,
   input  logic               lock_set,
   output logic               busy,
   output logic               poll_bit,
   output logic               ap_prog,
   output logic [MEM_AW-1:0]  ap_addr,
   output logic [DATA_W-1:0]  ap_data,
   output logic [NUM_SEC-1:0] ap_erase
);
   localparam int unsigned SEC_W  = MEM_AW - SEC_AW;
   localparam int unsigned MAX_PE = (PROG_CYCLES > ERASE_CYCLES) ? PROG_CYCLES : ERASE_CYCLES;
   localparam int unsigned MAX_C  = (MAX_PE > ABORT_CYCLES) ? MAX_PE : ABORT_CYCLES;
   localparam int unsigned CNT_W  = $clog2(MAX_C + 1);

   logic [CNT_W-1:0]   cnt;
   logic [NUM_SEC-1:0] locks, mask_q, sec_hot;
   logic [SEC_W-1:0]   sec;
   logic               hit, prog_q, done;

   assign sec = tgt_addr[MEM_AW-1:SEC_AW];
   assign hit = locks[sec];
   always_comb begin
      sec_hot      = '0;
      sec_hot[sec] = 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy     <= 1'b0;
         cnt      <= '0;
         locks    <= LOCK_INIT;
         mask_q   <= '0;
         prog_q   <= 1'b0;
         poll_bit <= 1'b0;
         ap_addr  <= '0;
         ap_data  <= '0;
      end else if (start) begin
         busy    <= 1'b1;
         ap_addr <= tgt_addr;
         ap_data <= tgt_data;
         case (op)
            OP_PROG: begin
               cnt      <= hit ? CNT_W'(ABORT_CYCLES - 1) : CNT_W'(PROG_CYCLES - 1);
               prog_q   <= ~hit;
               mask_q   <= '0;
               poll_bit <= ~tgt_data[DATA_W-1];
            end
            OP_SECT: begin
               cnt      <= hit ? CNT_W'(ABORT_CYCLES - 1) : CNT_W'(ERASE_CYCLES - 1);
               prog_q   <= 1'b0;
               mask_q   <= hit ? '0 : sec_hot;
               poll_bit <= 1'b0;
            end
            default: begin
               cnt      <= CNT_W'(ERASE_CYCLES - 1);
               prog_q   <= 1'b0;
               mask_q   <= ~locks;
               poll_bit <= 1'b0;
            end
         endcase
      end else begin
         if (lock_set) locks[sec] <= 1'b1;
         if (busy) begin
            if (cnt == '0) busy <= 1'b0;
            else           cnt  <= cnt - 1'b1;
         end
      end
   end

   assign done     = busy && (cnt == '0);
   assign ap_prog  = done & prog_q;
   assign ap_erase = done ? mask_q : '0;
endmodule

// File: rtl/flash_sector_store.sv
`timescale 1ns/1ps
module flash_sector_store #(
   parameter int unsigned DATA_W  = 8,
   parameter int unsigned MEM_AW  = 8,
   parameter int unsigned SEC_AW  = 5,
   parameter int unsigned NUM_SEC = 8
) (
   input  logic               clk,
   input  logic               wr_prog,
   input  logic [MEM_AW-1:0]  wr_addr,
   input  logic [DATA_W-1:0]  wr_data,
   input  logic [NUM_SEC-1:0] erase_mask,
   input  logic [MEM_AW-1:0]  rd_addr,
   output logic [DATA_W-1:0]  rd_data
);
   localparam int unsigned SEC_W     = MEM_AW - SEC_AW;
   localparam int unsigned SEC_BYTES = 1 << SEC_AW;

   logic [DATA_W-1:0] sec_rd [NUM_SEC];

   for (genvar s = 0; s < NUM_SEC; s++) begin : g_sec
      logic [DATA_W-1:0] cells [SEC_BYTES];
      logic              mine;

      initial begin
         for (int i = 0; i < SEC_BYTES; i++) cells[i] = '1;
      end

      assign mine = wr_prog && (wr_addr[MEM_AW-1:SEC_AW] == SEC_W'(s));

      always_ff @(posedge clk) begin
         if (erase_mask[s]) begin
            for (int i = 0; i < SEC_BYTES; i++) cells[i] <= '1;
         end else if (mine) begin
            cells[wr_addr[SEC_AW-1:0]] <= cells[wr_addr[SEC_AW-1:0]] & wr_data;
         end
      end

      assign sec_rd[s] = cells[rd_addr[SEC_AW-1:0]];
   end

   assign rd_data = sec_rd[rd_addr[MEM_AW-1:SEC_AW]];
endmodule

// File: rtl/flash_cmd_top.sv
`timescale 1ns/1ps
module flash_cmd_top
   import flash_pkg::*;
#(
   parameter int unsigned ADDR_W       = 12,
   parameter int unsigned DATA_W       = 8,
   parameter int unsigned MEM_AW       = 8,
   parameter int unsigned SEC_AW       = 5,
   parameter int unsigned PROG_CYCLES  = 16,
   parameter int unsigned ERASE_CYCLES = 64,
   parameter int unsigned ABORT_CYCLES = 400,
   parameter logic [(1 << (MEM_AW - SEC_AW))-1:0] LOCK_INIT = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ce_n,
   input  logic              oe_n,
   input  logic              we_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] din,
   output logic [DATA_W-1:0] dout,
   output logic              dout_oe
);
   localparam int unsigned NUM_SEC = 1 << (MEM_AW - SEC_AW);

   if (DATA_W != 8) begin : g_bad_width
      $error("flash_cmd_top: command codes and status bits need DATA_W == 8");
   end
   if (ADDR_W < 11 || ADDR_W < MEM_AW) begin : g_bad_addr
      $error("flash_cmd_top: ADDR_W must cover 555h and the array");
   end
   if (SEC_AW >= MEM_AW) begin : g_bad_sec
      $error("flash_cmd_top: need at least two sectors");
   end
   if (PROG_CYCLES < 1 || ERASE_CYCLES < 1 || ABORT_CYCLES < 1) begin : g_bad_time
      $error("flash_cmd_top: operation times must be at least one cycle");
   end

   logic               commit, rd_end, start, lock_set, busy, poll_bit, tog;
   logic               ap_prog;
   logic [ADDR_W-1:0]  addr_lat;
   logic [DATA_W-1:0]  data_lat, ap_data, rd_data;
   logic [MEM_AW-1:0]  ap_addr;
   logic [NUM_SEC-1:0] ap_erase;
   op_e                op;

   flash_bus_strobe #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_strobe (
      .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
      .addr(addr), .din(din), .commit(commit), .addr_lat(addr_lat),
      .data_lat(data_lat), .rd_end(rd_end)
   );

   flash_seq_decoder #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dec (
      .clk(clk), .rst_n(rst_n), .commit(commit), .busy(busy),
      .addr_lat(addr_lat), .data_lat(data_lat), .start(start), .op(op),
      .lock_set(lock_set)
   );

   flash_op_engine #(
      .DATA_W(DATA_W), .MEM_AW(MEM_AW), .SEC_AW(SEC_AW), .NUM_SEC(NUM_SEC),
      .PROG_CYCLES(PROG_CYCLES), .ERASE_CYCLES(ERASE_CYCLES),
      .ABORT_CYCLES(ABORT_CYCLES), .LOCK_INIT(LOCK_INIT)
   ) u_eng (
      .clk(clk), .rst_n(rst_n), .start(start), .op(op),
      .tgt_addr(addr_lat[MEM_AW-1:0]), .tgt_data(data_lat), .lock_set(lock_set),
      .busy(busy), .poll_bit(poll_bit), .ap_prog(ap_prog), .ap_addr(ap_addr),
      .ap_data(ap_data), .ap_erase(ap_erase)
   );

   flash_sector_store #(
      .DATA_W(DATA_W), .MEM_AW(MEM_AW), .SEC_AW(SEC_AW), .NUM_SEC(NUM_SEC)
   ) u_store (
      .clk(clk), .wr_prog(ap_prog), .wr_addr(ap_addr), .wr_data(ap_data),
      .erase_mask(ap_erase), .rd_addr(addr[MEM_AW-1:0]), .rd_data(rd_data)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               tog <= 1'b0;
      else if (start)           tog <= 1'b0;
      else if (busy && rd_end)  tog <= ~tog;
   end

   assign dout_oe = rst_n & ~ce_n & ~oe_n & we_n;
   assign dout    = busy ? {poll_bit, tog, {(DATA_W-2){1'b0}}} : rd_data;
endmodule

// File: rtl/flash_cmd_checker.sv
`timescale 1ns/1ps
module flash_cmd_checker #(
   parameter int unsigned MAX_BUSY = 512
) (
   input logic clk,
   input logic rst_n,
   input logic ce_n,
   input logic oe_n,
   input logic we_n,
   input logic dout_oe,
   input logic busy,
   input logic start
);
   int unsigned busy_len;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    busy_len <= 0;
      else if (!busy)                busy_len <= 0;
      else if (busy_len <= MAX_BUSY) busy_len <= busy_len + 1;
   end

   p_read_drives_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (!ce_n && !oe_n && we_n) |-> dout_oe);

   p_hiz_deselect_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (ce_n || oe_n) |-> !dout_oe);

   always @(posedge clk) begin
      if (!rst_n) begin
         p_hiz_in_reset_r4: assert (!dout_oe);
      end
   end

   p_start_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> busy);

   p_no_start_while_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !start);

   p_busy_bounded_r10: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (busy_len < MAX_BUSY));
endmodule

bind flash_cmd_top flash_cmd_checker #(
   .MAX_BUSY(PROG_CYCLES + ERASE_CYCLES + ABORT_CYCLES)
) u_chk (
   .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
   .dout_oe(dout_oe), .busy(busy), .start(start)
);

// File: tb/tb_flash_cmd_top.sv
`timescale 1ns/1ps
module tb_flash_cmd_top;
   localparam int unsigned T_PROG  = 10;
   localparam int unsigned T_ERASE = 60;
   localparam int unsigned T_ABORT = 40;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
   logic [11:0] addr = '0;
   logic [7:0]  din = '0;
   logic [7:0]  dout;
   logic        dout_oe;
   logic [7:0]  rv, rv2;
   logic        roe;
   int          checks = 0;
   int          errors = 0;

   // {address, written byte, byte expected afterwards}
   localparam logic [23:0] VEC [7] = '{
      24'h00_A5_A5, 24'h00_0F_05, 24'h21_3C_3C, 24'hFF_00_00,
      24'h7F_80_80, 24'h21_FF_3C, 24'h30_5A_5A
   };

   always #2.5 clk = ~clk;

   flash_cmd_top #(
      .PROG_CYCLES(T_PROG), .ERASE_CYCLES(T_ERASE), .ABORT_CYCLES(T_ABORT)
   ) dut (
      .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
      .addr(addr), .din(din), .dout(dout), .dout_oe(dout_oe)
   );

   task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: got %h expected %h", req, got, exp);
      end
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   // strobe opens with (a,d); (a2,d2) are applied while it is open
   task automatic bwr2(input logic [11:0] a, input logic [7:0] d,
                       input logic [11:0] a2, input logic [7:0] d2);
      @(negedge clk); addr = a; din = d; oe_n = 1'b1; ce_n = 1'b0;
      @(negedge clk); we_n = 1'b0;
      @(negedge clk); addr = a2; din = d2;
      @(negedge clk); we_n = 1'b1;
      @(negedge clk); ce_n = 1'b1;
   endtask

   task automatic bwr(input logic [11:0] a, input logic [7:0] d);
      bwr2(a, d, a, d);
   endtask

   task automatic brd(input logic [11:0] a);
      @(negedge clk); addr = a; ce_n = 1'b0; oe_n = 1'b0;
      @(negedge clk); rv = dout; roe = dout_oe;
      oe_n = 1'b1; ce_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic prog(input logic [11:0] a, input logic [7:0] d);
      bwr(12'h555, 8'hAA); bwr(12'h2AA, 8'h55); bwr(12'h555, 8'hA0); bwr(a, d);
   endtask

   task automatic erase_pre();
      bwr(12'h555, 8'hAA); bwr(12'h2AA, 8'h55); bwr(12'h555, 8'h80);
      bwr(12'h555, 8'hAA); bwr(12'h2AA, 8'h55);
   endtask

   initial begin
      #1000000;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      // reset state
      idle(2);
      @(negedge clk); ce_n = 1'b0; oe_n = 1'b0;
      @(negedge clk); chk("R4 oe in reset", {7'd0, dout_oe}, 8'h00);
      ce_n = 1'b1; oe_n = 1'b1;
      idle(2); rst_n = 1'b1; idle(2);
      brd(12'h000);
      chk("R1 oe", {7'd0, roe}, 8'h01);
      chk("R5 erased", rv, 8'hFF);
      @(negedge clk); ce_n = 1'b0; oe_n = 1'b1;
      @(negedge clk); chk("R2 oe high", {7'd0, dout_oe}, 8'h00);
      ce_n = 1'b1; oe_n = 1'b0;
      @(negedge clk); chk("R2 ce high", {7'd0, dout_oe}, 8'h00);
      oe_n = 1'b1;

      // program vector table
      for (int i = 0; i < 7; i++) begin
         prog({4'h0, VEC[i][23:16]}, VEC[i][15:8]);
         idle(T_PROG + 10);
         brd({4'h0, VEC[i][23:16]});
         chk("R5 R6 R10 program", rv, VEC[i][7:0]);
      end

      // status during program
      prog(12'h010, 8'h7E);
      brd(12'h010); chk("R11 status first", rv, 8'h80);
      brd(12'h010); chk("R11 status second", rv, 8'hC0);
      idle(T_PROG + 10);
      brd(12'h010); chk("R10 back to data", rv, 8'h7E);

      // sector erase of sector 0
      erase_pre(); bwr(12'h005, 8'h30);
      idle(20);
      brd(12'h000); chk("R11 erase status", rv, 8'h00);
      idle(T_ERASE);
      brd(12'h000); chk("R7 sector erased 00", rv, 8'hFF);
      brd(12'h010); chk("R7 sector erased 10", rv, 8'hFF);
      brd(12'h021); chk("R7 other sector kept", rv, 8'h3C);

      // lockdown of sector 2
      prog(12'h040, 8'h12); idle(T_PROG + 10);
      bwr(12'h555, 8'hAA); bwr(12'h2AA, 8'h55); bwr(12'h555, 8'h60); bwr(12'h040, 8'h40);
      prog(12'h040, 8'h00);
      idle(20);
      brd(12'h040); chk("R9 locked program busy", rv, 8'h80);
      idle(30);
      brd(12'h040); chk("R9 R13 locked program", rv, 8'h12);
      erase_pre(); bwr(12'h045, 8'h30);
      idle(20);
      brd(12'h040); chk("R9 locked erase busy", rv, 8'h00);
      idle(30);
      brd(12'h040); chk("R9 locked erase abort", rv, 8'h12);

      // chip erase
      erase_pre(); bwr(12'h555, 8'h10);
      idle(T_ERASE + 10);
      brd(12'h040); chk("R9 chip erase skips lock", rv, 8'h12);
      brd(12'h021); chk("R7 chip erase", rv, 8'hFF);
      brd(12'h0FF); chk("R7 chip erase top", rv, 8'hFF);

      // writes during busy
      erase_pre(); bwr(12'h065, 8'h30);
      prog(12'h022, 8'h00);
      idle(T_ERASE);
      brd(12'h022); chk("R8 busy write ignored", rv, 8'hFF);

      // broken sequences
      bwr(12'h555, 8'hAA); bwr(12'h2AA, 8'h55); bwr(12'h555, 8'h55);
      bwr(12'h555, 8'hA0); bwr(12'h023, 8'h00);
      idle(T_PROG + 5);
      brd(12'h023); chk("R12 bad code", rv, 8'hFF);
      bwr(12'h554, 8'hAA); bwr(12'h2AA, 8'h55); bwr(12'h555, 8'hA0); bwr(12'h023, 8'h00);
      idle(T_PROG + 5);
      brd(12'h023); chk("R12 bad address", rv, 8'hFF);

      // address latched at strobe start, data at strobe end
      bwr(12'h555, 8'hAA); bwr(12'h2AA, 8'h55); bwr(12'h555, 8'hA0);
      bwr2(12'h024, 8'hFF, 12'h025, 8'h0F);
      idle(T_PROG + 10);
      brd(12'h024); chk("R3 address and data", rv, 8'h0F);
      brd(12'h025); chk("R3 moved address", rv, 8'hFF);

      // reset during operation
      erase_pre(); bwr(12'h030, 8'h30);
      idle(5);
      @(negedge clk); rst_n = 1'b0; ce_n = 1'b0; oe_n = 1'b0;
      @(negedge clk); chk("R4 oe during reset", {7'd0, dout_oe}, 8'h00);
      ce_n = 1'b1; oe_n = 1'b1;
      @(negedge clk); rst_n = 1'b1; idle(2);
      brd(12'h030); rv2 = rv;
      brd(12'h030);
      chk("R4 read mode after reset", rv, rv2);
      chk("R4 oe after reset", {7'd0, roe}, 8'h01);
      prog(12'h040, 8'h10); idle(T_PROG + 10);
      brd(12'h040); chk("R4 R13 locks reloaded", rv, 8'h10);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule